// File: doc/BRIEF.md
# Quadword Bit-Field Extract and Insert Unit

This unit operates on the low 64-bit quadword of vector operands and performs one of two bit-field operations per request. In extract mode the destination quadword is shifted right by a shift amount and trimmed to a field of a given length. In insert mode a field of the given length, taken from the low bits of a source quadword, is written into the destination quadword at a given bit offset. All other destination bits are left unchanged.

The field length and offset come from one of two places. They can come from two immediate byte inputs. They can also come from fixed control bytes inside the operands. In both cases only the low six bits of each value are used. A length of zero selects a full 64-bit field. The result is registered and reported with a valid strobe one cycle after the request. The upper half of the vector register and instruction decode are handled elsewhere.

Top module: `bfx_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid` and `res_q` are both 0 after that edge.
- R2: `res_valid` is 1 in exactly the cycles that follow a clock edge at which `req_valid` was 1, and the result of that request is on `res_q` in the same cycle.
- R3: Only bits [5:0] of the length and shift bytes are used. Bits [7:6] have no effect on the result.
- R4: Extract (`op_insert`=0) returns `(dst_q >> shift)` masked to its low `len` bits. When `len` is 0, the shifted value is returned unmasked.
- R5: Insert (`op_insert`=1) uses a mask of `len` ones, or 64 ones when `len` is 0. The result is `(dst_q & ~(mask<<shift)) | ((src_lo & mask) << shift)`, truncated to 64 bits. Field bits that would land above bit 63 are dropped silently.
- R6: With `ctrl_from_reg`=0, the length is `imm_len` and the shift is `imm_shift`, for both operations.
- R7: Extract with `ctrl_from_reg`=1 takes the length from `src_lo[7:0]` and the shift from `src_lo[15:8]`.
- R8: Insert with `ctrl_from_reg`=1 takes the length from `src_hi[7:0]` and the shift from `src_hi[15:8]`. The field data is still `src_lo`.
- R9: In a cycle after an edge with `req_valid`=0, `res_q` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op_insert | input | 1 | 0 = extract, 1 = insert |
| ctrl_from_reg | input | 1 | 0 = immediates give length/shift, 1 = operand control bytes |
| imm_len | input | 8 | Immediate field length |
| imm_shift | input | 8 | Immediate field offset |
| dst_q | input | 64 | Destination low quadword |
| src_lo | input | 64 | Source low quadword (field data, or extract control) |
| src_hi | input | 64 | Source high quadword (insert control in bytes 0 and 1) |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_q | output | 64 | New destination low quadword |

## Verification
The hardest cases to reach from the ports are inserts where length plus shift goes past 64, so that part of the field must be dropped. The zero-length case is equally hard, because it has to switch over to a full-width mask rather than an empty one. The stimulus sweeps every one of the 4096 length and shift pairs for both operations against pseudo-random quadwords. That sweep covers len=0, shift=63 and every overflow combination. Separate passes set the ignored upper bits of the control bytes, route control through the operand bytes with conflicting immediates, and idle the request while the inputs change.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
  localparam int CTRL_BYTE_W = 8;

  typedef enum logic {
    BFX_EXTRACT = 1'b0,
    BFX_INSERT  = 1'b1
  } bfx_op_e;
endpackage

// File: rtl/bfx_ctrl_sel.sv
`timescale 1ns/1ps
module bfx_ctrl_sel #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = bfx_pkg::CTRL_BYTE_W,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              from_reg,
  input  logic              is_insert,
  input  logic [BYTE_W-1:0] imm_len,
  input  logic [BYTE_W-1:0] imm_shift,
  input  logic [BYTE_W-1:0] lo_len_byte,
  input  logic [BYTE_W-1:0] lo_sh_byte,
  input  logic [BYTE_W-1:0] hi_len_byte,
  input  logic [BYTE_W-1:0] hi_sh_byte,
  output logic [SH_W-1:0]   fld_len,
  output logic [SH_W-1:0]   fld_shift
);
  logic [BYTE_W-1:0] len_byte, sh_byte;
  logic unused_upper;

  always_comb begin
    if (!from_reg) begin
      len_byte = imm_len;
      sh_byte  = imm_shift;
    end else if (is_insert) begin
      len_byte = hi_len_byte;
      sh_byte  = hi_sh_byte;
    end else begin
      len_byte = lo_len_byte;
      sh_byte  = lo_sh_byte;
    end
  end

  assign fld_len      = len_byte[SH_W-1:0];
  assign fld_shift    = sh_byte[SH_W-1:0];
  assign unused_upper = ^{len_byte[BYTE_W-1:SH_W], sh_byte[BYTE_W-1:SH_W]};
endmodule

// File: rtl/bfx_extract.sv
`timescale 1ns/1ps
module bfx_extract #(
  parameter int DATA_W = 64,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [SH_W-1:0]   len,
  input  logic [SH_W-1:0]   shift,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] shifted, mask;

  always_comb begin
    shifted = dst >> shift;
    mask    = (DATA_W'(1) << len) - DATA_W'(1);
    res     = (len == '0) ? shifted : (shifted & mask);
  end
endmodule

// File: rtl/bfx_insert.sv
`timescale 1ns/1ps
module bfx_insert #(
  parameter int DATA_W = 64,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [SH_W-1:0]   len,
  input  logic [SH_W-1:0]   shift,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] mask, hole, field;

  always_comb begin
    mask  = (len == '0) ? '1 : ((DATA_W'(1) << len) - DATA_W'(1));
    hole  = mask << shift;
    field = (src & mask) << shift;
    res   = (dst & ~hole) | field;
  end
endmodule

// File: rtl/bfx_unit.sv
`timescale 1ns/1ps
module bfx_unit #(
  parameter int DATA_W = 64,
  localparam int BYTE_W = bfx_pkg::CTRL_BYTE_W,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              op_insert,
  input  logic              ctrl_from_reg,
  input  logic [BYTE_W-1:0] imm_len,
  input  logic [BYTE_W-1:0] imm_shift,
  input  logic [DATA_W-1:0] dst_q,
  input  logic [DATA_W-1:0] src_lo,
  input  logic [DATA_W-1:0] src_hi,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_q
);
  import bfx_pkg::*;

  logic [SH_W-1:0]   fld_len, fld_shift;
  logic [DATA_W-1:0] ext_res, ins_res, next_res;
  bfx_op_e           op;
  logic              unused_hi;

  assign op        = bfx_op_e'(op_insert);
  assign unused_hi = ^src_hi[DATA_W-1:2*BYTE_W];

  bfx_ctrl_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctrl (
    .from_reg    (ctrl_from_reg),
    .is_insert   (op == BFX_INSERT),
    .imm_len     (imm_len),
    .imm_shift   (imm_shift),
    .lo_len_byte (src_lo[BYTE_W-1:0]),
    .lo_sh_byte  (src_lo[2*BYTE_W-1:BYTE_W]),
    .hi_len_byte (src_hi[BYTE_W-1:0]),
    .hi_sh_byte  (src_hi[2*BYTE_W-1:BYTE_W]),
    .fld_len     (fld_len),
    .fld_shift   (fld_shift)
  );

  bfx_extract #(.DATA_W(DATA_W)) u_ext (
    .dst   (dst_q),
    .len   (fld_len),
    .shift (fld_shift),
    .res   (ext_res)
  );

  bfx_insert #(.DATA_W(DATA_W)) u_ins (
    .dst   (dst_q),
    .src   (src_lo),
    .len   (fld_len),
    .shift (fld_shift),
    .res   (ins_res)
  );

  assign next_res = (op == BFX_INSERT) ? ins_res : ext_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_q <= next_res;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
`timescale 1ns/1ps
module bfx_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              op_insert,
  input logic              ctrl_from_reg,
  input logic [7:0]        imm_len,
  input logic [7:0]        imm_shift,
  input logic [DATA_W-1:0] dst_q,
  input logic [DATA_W-1:0] src_lo,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_q
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && res_q == '0));

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_q));

  p_ext_identity_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_insert && !ctrl_from_reg &&
     imm_len[5:0] == 6'd0 && imm_shift[5:0] == 6'd0) |=> res_q == $past(dst_q));

  p_ext_width_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_insert && !ctrl_from_reg && imm_len[5:0] != 6'd0)
      |=> (res_q >> $past(imm_len[5:0])) == '0);

  p_ins_full_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_insert && !ctrl_from_reg &&
     imm_len[5:0] == 6'd0 && imm_shift[5:0] == 6'd0) |=> res_q == $past(src_lo));
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .op_insert     (op_insert),
  .ctrl_from_reg (ctrl_from_reg),
  .imm_len       (imm_len),
  .imm_shift     (imm_shift),
  .dst_q         (dst_q),
  .src_lo        (src_lo),
  .res_valid     (res_valid),
  .res_q         (res_q)
);

// File: tb/bfx_unit_tb.sv
`timescale 1ns/1ps
module bfx_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, op_insert, ctrl_from_reg;
  logic [7:0]  imm_len, imm_shift;
  logic [63:0] dst_q, src_lo, src_hi;
  logic        res_valid;
  logic [63:0] res_q;

  int n_vec  = 0;
  int n_fail = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  bfx_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_insert(op_insert),
    .ctrl_from_reg(ctrl_from_reg), .imm_len(imm_len), .imm_shift(imm_shift),
    .dst_q(dst_q), .src_lo(src_lo), .src_hi(src_hi),
    .res_valid(res_valid), .res_q(res_q)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    return s * 64'd6364136223846793005 + 64'd1442695040888963407;
  endfunction

  function automatic logic [63:0] model(input logic ins, input logic [7:0] l8,
                                        input logic [7:0] s8, input logic [63:0] d,
                                        input logic [63:0] s);
    int l = int'(l8 & 8'h3f);
    int sh = int'(s8 & 8'h3f);
    logic [63:0] m;
    m = (l == 0) ? {64{1'b1}} : ((64'd1 << l) - 64'd1);
    if (!ins) return (d >> sh) & m;
    return (d & ~(m << sh)) | ((s & m) << sh);
  endfunction

  task automatic check(input string req, input logic [63:0] exp_q, input logic exp_v);
    n_vec++;
    if (res_q !== exp_q || res_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s: res_q=%h res_valid=%b expected res_q=%h res_valid=%b",
               req, res_q, res_valid, exp_q, exp_v);
    end
  endtask

  // Drive at negedge, result registered at posedge, sample at next negedge.
  task automatic apply(input string req, input logic ins, input logic fromreg,
                       input logic [7:0] l8, input logic [7:0] s8,
                       input logic [63:0] d, input logic [63:0] slo,
                       input logic [63:0] shi, input logic [63:0] exp_q);
    req_valid = 1'b1; op_insert = ins; ctrl_from_reg = fromreg;
    imm_len = l8; imm_shift = s8; dst_q = d; src_lo = slo; src_hi = shi;
    @(posedge clk); @(negedge clk);
    check(req, exp_q, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; req_valid = 1'b1; op_insert = 1'b1; ctrl_from_reg = 1'b0;
    imm_len = 8'd5; imm_shift = 8'd3; dst_q = '1; src_lo = '1; src_hi = '0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", 64'd0, 1'b0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check("R2 idle after reset", 64'd0, 1'b0);

    // R4/R5/R6: full sweep of length and shift for both operations
    for (int op = 0; op < 2; op++) begin
      for (int l = 0; l < 64; l++) begin
        for (int s = 0; s < 64; s++) begin
          logic [63:0] d, x;
          lfsr = next_rand(lfsr); d = lfsr;
          lfsr = next_rand(lfsr); x = lfsr;
          apply(op ? "R5 insert sweep (R6)" : "R4 extract sweep (R6)", op[0], 1'b0,
                8'(l), 8'(s), d, x, ~x, model(op[0], 8'(l), 8'(s), d, x));
        end
      end
    end

    // Named corners: len=0, shift=63, overflow past bit 63
    apply("R4 extract len0 shift63", 1'b0, 1'b0, 8'd0, 8'd63,
          64'h8000_0000_0000_0000, 64'd0, 64'd0, 64'd1);
    apply("R5 insert len0 shift63", 1'b1, 1'b0, 8'd0, 8'd63,
          64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0003, 64'd0,
          64'h8123_4567_89AB_CDEF);
    apply("R5 insert overflow drop", 1'b1, 1'b0, 8'd16, 8'd56,
          64'd0, 64'h0000_0000_0000_ABCD, 64'd0, 64'hCD00_0000_0000_0000);

    // R3: upper bits of control bytes ignored
    for (int k = 0; k < 64; k++) begin
      logic [63:0] d, x;
      logic [7:0] l8, s8;
      lfsr = next_rand(lfsr); d = lfsr;
      lfsr = next_rand(lfsr); x = lfsr;
      l8 = {lfsr[9:8], lfsr[5:0]} | 8'hC0;
      s8 = {lfsr[19:18], lfsr[15:10]} | 8'h40;
      apply("R3 upper control bits ignored", k[0], 1'b0, l8, s8, d, x, 64'd0,
            model(k[0], {2'b00, l8[5:0]}, {2'b00, s8[5:0]}, d, x));
    end

    // R7: extract control from src_lo bytes 0/1, immediates conflict
    for (int k = 0; k < 128; k++) begin
      logic [63:0] d, x;
      lfsr = next_rand(lfsr); d = lfsr;
      lfsr = next_rand(lfsr); x = lfsr;
      apply("R7 extract register control", 1'b0, 1'b1, ~x[7:0], ~x[15:8], d, x, ~d,
            model(1'b0, x[7:0], x[15:8], d, x));
    end

    // R8: insert control from src_hi bytes 0/1, data from src_lo
    for (int k = 0; k < 128; k++) begin
      logic [63:0] d, x, h;
      lfsr = next_rand(lfsr); d = lfsr;
      lfsr = next_rand(lfsr); x = lfsr;
      lfsr = next_rand(lfsr); h = lfsr;
      apply("R8 insert register control", 1'b1, 1'b1, x[7:0], x[15:8], d, x, h,
            model(1'b1, h[7:0], h[15:8], d, x));
    end

    // R9 / R2: idle request holds result, valid drops
    held = model(1'b1, 8'd8, 8'd8, 64'h1111_2222_3333_4444, 64'hFF);
    apply("R5 before hold", 1'b1, 1'b0, 8'd8, 8'd8, 64'h1111_2222_3333_4444, 64'hFF, 0, held);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      lfsr = next_rand(lfsr);
      dst_q = lfsr; src_lo = ~lfsr; imm_len = lfsr[7:0]; op_insert = lfsr[9];
      @(posedge clk); @(negedge clk);
      check("R9 hold while idle (R2 valid low)", held, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule